// File: doc/BRIEF.md
# Dual-Bank Boot Sequence Arbiter

At power-up, this block decides which of two boot flash banks becomes the active (lower) address region. After reset is released it reads one 32-bit sequence word from each bank through a simple synchronous read port. That port has one cycle of read latency. The block then checks each word for integrity and compares the two. The result appears as a swap indication, an "all words invalid" flag and a done strobe. The address decoder that applies the mapping is a separate block and consumes these outputs. They stay frozen until the next reset.

Each sequence word carries a 16-bit sequence number in its low half. Its high half holds a check field that must be the bitwise inverse of the sequence number. The valid word with the larger sequence number wins, and a tie goes to bank 1. If only one word is valid, that bank wins. If neither word is valid, bank 1 is used and the invalid flag is raised.

The controller is a five-state machine:
- IDLE: the first cycle after reset. It always moves to READ1.
- READ1: requests the bank 1 word, then moves to READ2.
- READ2: captures the bank 1 word and requests the bank 2 word, then moves to COMPARE.
- COMPARE: takes the bank 2 word straight from the read port, decides the winner, registers the result and moves to DONE.
- DONE: holds the result with no further reads. It exits only on reset.

Top module: `boot_bank_arbiter`

## Requirements
- R1: While reset is asserted, and after it until the result is ready, `done`, `swap` and `no_valid` are all 0.
- R2: After reset, exactly two reads are issued on consecutive cycles: first at address `BANK1_ADDR`, then at `BANK2_ADDR`. Each `rd_req` lasts one cycle. The read data is taken from `rd_data` in the cycle after the request.
- R3: A word is valid only when bits [31:16] equal the bitwise inverse of bits [15:0]. For example, 0xFFFB0004 is valid and 0xFFFB0005 is not.
- R4: When both words are valid and the bank 1 sequence is greater, `swap` is 0.
- R5: When both words are valid with equal sequences, `swap` is 0.
- R6: When both words are valid and the bank 2 sequence is greater, `swap` is 1. A value of 1 means bank 2 is in the lower region.
- R7: When exactly one word is valid, that bank wins regardless of sequence values. `swap` is 1 only if bank 2 alone is valid, and `no_valid` is 0.
- R8: When neither word is valid, `swap` is 0 and `no_valid` is 1.
- R9: Sequence comparison is unsigned over the 16-bit sequence field. For example, 0x8000 beats 0x7FFF.
- R10: `done` rises on the fourth rising clock edge after reset is released. `swap` and `no_valid` take their final values on that same edge.
- R11: Once `done` is 1, all outputs hold their values, no further reads are issued, and changes on `rd_data` have no effect.
- R12: Asserting reset again clears the result, and a full new arbitration runs after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | output | 1 | Read request to the boot flash port |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 2*SEQ_W | Read data, valid one cycle after `rd_req` |
| done | output | 1 | Arbitration result valid, held until reset |
| swap | output | 1 | 1: bank 2 is in the lower region; 0: bank 1 is in the lower region |
| no_valid | output | 1 | Neither sequence word passed its check |

## Verification
The assertions check four things on every cycle:
- outputs stay quiet before `done`;
- a bank 2 read is always preceded by a bank 1 read;
- no read is issued once `done` is set;
- the result stays frozen after `done`, and `no_valid` never appears together with `swap`.

Which bank actually wins under each combination of validity and sequence order can only be shown by the bench's scenarios. The same holds for unsigned ordering at the 0x7FFF/0x8000 boundary, the exact edge on which `done` rises, and a rerun after a second reset.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ1   = 3'd1,
        ST_READ2   = 3'd2,
        ST_COMPARE = 3'd3,
        ST_DONE    = 3'd4
    } arb_state_e;

    typedef enum logic {
        PICK_BANK1 = 1'b0,
        PICK_BANK2 = 1'b1
    } bank_pick_e;

endpackage

// File: rtl/seq_word_check.sv
module seq_word_check #(
    parameter int SEQ_W = 16
) (
    input  logic [2*SEQ_W-1:0] word_in,
    output logic [SEQ_W-1:0]   seq_out,
    output logic               word_ok
);
    logic [SEQ_W-1:0] chk_field;

    always_comb begin
        seq_out   = word_in[SEQ_W-1:0];
        chk_field = word_in[2*SEQ_W-1:SEQ_W];
        word_ok   = (chk_field == ~seq_out);   // R3
    end
endmodule

// File: rtl/bank_pick.sv
module bank_pick
    import bootsel_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             ok_a,
    input  logic [SEQ_W-1:0] seq_a,
    input  logic             ok_b,
    input  logic [SEQ_W-1:0] seq_b,
    output bank_pick_e       winner,
    output logic             none_ok
);
    always_comb begin
        none_ok = !ok_a && !ok_b;
        if (ok_a && ok_b) begin
            // unsigned compare, tie keeps bank 1 (R5, R9)
            winner = (seq_b > seq_a) ? PICK_BANK2 : PICK_BANK1;
        end else if (ok_b) begin
            winner = PICK_BANK2;                 // R7
        end else begin
            winner = PICK_BANK1;                 // R7, R8
        end
    end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import bootsel_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter int              WORD_W     = 32,
    parameter logic [ADDR_W-1:0] BANK1_ADDR = '0,
    parameter logic [ADDR_W-1:0] BANK2_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] first_word,
    input  bank_pick_e        winner,
    input  logic              none_ok,
    output logic              done_q,
    output logic              swap_q,
    output logic              none_q
);
    arb_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_READ1;
            ST_READ1:   state_d = ST_READ2;
            ST_READ2:   state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // read port drive
    always_comb begin
        rd_req  = 1'b0;
        rd_addr = BANK1_ADDR;
        unique case (state_q)
            ST_READ1: begin rd_req = 1'b1; rd_addr = BANK1_ADDR; end
            ST_READ2: begin rd_req = 1'b1; rd_addr = BANK2_ADDR; end
            default:  begin rd_req = 1'b0; rd_addr = BANK1_ADDR; end
        endcase
    end

    // registered outputs and captured bank 1 word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_word <= '0;
            done_q     <= 1'b0;
            swap_q     <= 1'b0;
            none_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_READ2:   first_word <= rd_data;
                ST_COMPARE: begin
                    done_q <= 1'b1;
                    swap_q <= (winner == PICK_BANK2);
                    none_q <= none_ok;
                end
                default: ;
            endcase
        end
    end

    AST_QUIET_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (!swap_q && !none_q)); // R1
    AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_addr == BANK2_ADDR) |-> ($past(rd_req) && $past(rd_addr) == BANK1_ADDR)); // R2
    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && $stable(swap_q) && $stable(none_q))); // R11
    AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !rd_req); // R11
    AST_INVALID_KEEPS_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
        none_q |-> !swap_q); // R8
endmodule

// File: rtl/boot_bank_arbiter.sv
module boot_bank_arbiter
    import bootsel_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                SEQ_W      = 16,
    parameter logic [ADDR_W-1:0] BANK1_ADDR = 12'h0F0,
    parameter logic [ADDR_W-1:0] BANK2_ADDR = 12'h1F0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [2*SEQ_W-1:0]   rd_data,
    output logic                 done,
    output logic                 swap,
    output logic                 no_valid
);
    localparam int WORD_W  = 2 * SEQ_W;
    localparam int N_BANKS = 2;

    logic [WORD_W-1:0] first_word;
    logic [WORD_W-1:0] words  [N_BANKS];
    logic [SEQ_W-1:0]  seqs   [N_BANKS];
    logic              oks    [N_BANKS];
    bank_pick_e        winner;
    logic              none_ok;

    assign words[0] = first_word;   // bank 1, captured in READ2
    assign words[1] = rd_data;      // bank 2, live in COMPARE

    for (genvar b = 0; b < N_BANKS; b++) begin : g_check
        seq_word_check #(.SEQ_W(SEQ_W)) i_check (
            .word_in (words[b]),
            .seq_out (seqs[b]),
            .word_ok (oks[b])
        );
    end

    bank_pick #(.SEQ_W(SEQ_W)) i_pick (
        .ok_a    (oks[0]),
        .seq_a   (seqs[0]),
        .ok_b    (oks[1]),
        .seq_b   (seqs[1]),
        .winner  (winner),
        .none_ok (none_ok)
    );

    arb_ctrl #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .BANK1_ADDR (BANK1_ADDR),
        .BANK2_ADDR (BANK2_ADDR)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .first_word (first_word),
        .winner     (winner),
        .none_ok    (none_ok),
        .done_q     (done),
        .swap_q     (swap),
        .none_q     (no_valid)
    );
endmodule

// File: tb/test_boot_bank_arbiter.sv
`timescale 1ns/1ps
module test_boot_bank_arbiter;
    localparam int          ADDR_W = 12;
    localparam logic [11:0] A1 = 12'h0F0;
    localparam logic [11:0] A2 = 12'h1F0;

    typedef struct {
        logic  eswap;
        logic  enone;
        string tag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [31:0]       rd_data = '0;
    logic              done, swap, no_valid;

    logic [31:0] mem1 = '0, mem2 = '0;
    int          n_reads = 0;
    logic [11:0] addr_log0 = '0, addr_log1 = '0;
    int          cyc = 0;
    int          n_checks = 0, n_fails = 0;
    bit          seen = 0;
    exp_item_t   exp_q[$];

    always #2 clk = ~clk;

    boot_bank_arbiter i_boot_bank_arbiter (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .swap(swap), .no_valid(no_valid)
    );

    // memory model: one cycle latency
    always @(posedge clk) begin
        if (rd_req) rd_data <= (rd_addr == A1) ? mem1 : (rd_addr == A2) ? mem2 : 32'h0BAD_0BAD;
        if (!rst_n) begin
            n_reads <= 0;
        end else if (rd_req) begin
            if (n_reads == 0) addr_log0 <= rd_addr;
            if (n_reads == 1) addr_log1 <= rd_addr;
            n_reads <= n_reads + 1;
        end
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop expected result when done first appears
    always @(negedge clk) begin
        if (!rst_n) begin
            seen = 0;
        end else if (done && !seen) begin
            exp_item_t it;
            seen = 1;
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected done", 32'(done), 32'd0);
            end else begin
                it = exp_q.pop_front();
                check(swap == it.eswap, it.tag, "swap", 32'(swap), 32'(it.eswap));
                check(no_valid == it.enone, it.tag, "no_valid", 32'(no_valid), 32'(it.enone));
                check(cyc == 4, "R10", "edges to done", 32'(cyc), 32'd4);
                check(n_reads == 2, "R2", "read count", 32'(n_reads), 32'd2);
                check(addr_log0 == A1, "R2", "first read addr", 32'(addr_log0), 32'(A1));
                check(addr_log1 == A2, "R2", "second read addr", 32'(addr_log1), 32'(A2));
            end
        end
    end

    task automatic run_case(input logic [31:0] w1, input logic [31:0] w2,
                            input logic es, input logic en, input string tag);
        exp_item_t it;
        logic s0, n0;
        @(negedge clk);
        rst_n = 1'b0;
        mem1 = w1;
        mem2 = w2;
        it.eswap = es; it.enone = en; it.tag = tag;
        exp_q.push_back(it);
        repeat (2) @(negedge clk);
        check(!done && !swap && !no_valid, "R1", "outputs in reset",
              {29'd0, done, swap, no_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !swap && !no_valid, "R1", "outputs before done",
              {29'd0, done, swap, no_valid}, 32'd0);
        for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R10", "result produced", 32'(exp_q.size()), 32'd0);
        // R11: disturb memory, outputs and read count must not move
        s0 = swap; n0 = no_valid;
        mem1 = ~w1; mem2 = ~w2;
        repeat (6) @(negedge clk);
        check(done && swap == s0 && no_valid == n0, "R11", "held result",
              {29'd0, done, swap, no_valid}, {29'd0, 1'b1, s0, n0});
        check(n_reads == 2, "R11", "no reads after done", 32'(n_reads), 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_case(32'hFFFA_0005, 32'hFFFB_0004, 1'b0, 1'b0, "R4");
        run_case(32'hFFFB_0004, 32'hFFFA_0005, 1'b1, 1'b0, "R6");
        run_case(32'hFFF0_000F, 32'hFFF0_000F, 1'b0, 1'b0, "R5");
        run_case(32'hFFFB_0005, 32'hFFFE_0001, 1'b1, 1'b0, "R3");
        run_case(32'h1234_0001, 32'hFFF0_000F, 1'b1, 1'b0, "R7");
        run_case(32'hFF00_00FF, 32'h0000_0000, 1'b0, 1'b0, "R7");
        run_case(32'h0000_0000, 32'h1111_2222, 1'b0, 1'b1, "R8");
        run_case(32'h7FFF_8000, 32'h8000_7FFF, 1'b0, 1'b0, "R9");
        run_case(32'h8000_7FFF, 32'h7FFF_8000, 1'b1, 1'b0, "R9");
        run_case(32'h0000_FFFF, 32'hFFFF_0000, 1'b0, 1'b0, "R4");
        // R12: rerun after a second reset with the opposite outcome
        run_case(32'hFFFF_0000, 32'h0000_FFFF, 1'b1, 1'b0, "R12");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog (R10): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule